// File: doc/BRIEF.md
# Profiling Overflow Event Counters

This block holds five small performance counters for a processor core. Each one counts a different class of cycle or instruction, reported by the core as one-cycle qualifier strobes. The classes are extra instruction cycles, exception-handling overhead cycles, sleep cycles, extra load/store cycles, and instructions that retire in zero cycles (folded instructions). Every counter is `CNT_W` bits wide (8 by default) and wraps modulo 2^`CNT_W`. When a counter wraps while its event-enable pin is high, it raises a single-cycle overflow event pulse. Downstream trace logic can turn these pulses into profiling packets.

Software or a debugger can load any counter through a simple write port and can read any counter through a read-select port. All five values are also presented side by side on a flat output bus. A counter is cleared in the cycle after its event enable rises from 0 to 1, so each profiling window starts from zero.

Top module: `perf_event_counters`

## Requirements
- R1: After reset every counter reads 0, and no event pulse is high.
- R2: `rd_data` returns the selected counter zero-extended, with bits above the counter width reading 0. Select codes are: 0 extra-cycle, 1 exception, 2 sleep, 3 load/store, 4 folded. Codes 5 to 7 read 0. The same codes are used by `wr_sel`, by the lane order of `cnt_all` (lane i at bits [8i+7:8i]) and by the bit order of `evt_en` and `evt_pulse`.
- R3: The extra-cycle counter adds 1 in a cycle when `fetch_stall_stb` is high. It also adds 1 when `instr_extra_stb` is high and `lsu_extra_stb` is low. Otherwise it holds.
- R4: The load/store counter adds 1 in every cycle that `lsu_extra_stb` is high. For example, a four-cycle load strobes three cycles and adds 3.
- R5: The exception counter adds 1 per cycle of `exc_stb`, and the sleep counter adds 1 per cycle of `sleep_stb`.
- R6: The folded counter adds `fold_n` each cycle, up to 2. A `fold_n` of 3 adds 2.
- R7: Counters wrap modulo 256. Adding past 255 leaves the remainder.
- R8: A wrap with the lane's `evt_en` high produces `evt_pulse` high for exactly the one cycle after the wrapping edge.
- R9: A wrap with the lane's `evt_en` low produces no event, and the counter still wraps.
- R10: In the cycle after `evt_en` rises from 0 to 1, the counter reads 0, whatever its increment strobe was doing.
- R11: A write (`wr_en`, `wr_sel`) loads `wr_data` into the counter. The write takes priority over both the increment and the enable clear, and it never produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_extra_stb | input | 1 | Instruction is in a cycle beyond its first |
| lsu_extra_stb | input | 1 | Load/store is in a cycle beyond its first |
| fetch_stall_stb | input | 1 | Instruction fetch is stalled this cycle |
| exc_stb | input | 1 | Exception entry, return or pre-emption cycle |
| sleep_stb | input | 1 | Core is sleeping this cycle |
| fold_n | input | 2 | Number of zero-cycle instructions retired this cycle |
| evt_en | input | 5 | Per-counter event enable |
| wr_en | input | 1 | Counter write strobe |
| wr_sel | input | 3 | Counter selected for writing |
| wr_data | input | 8 | Value to load |
| rd_sel | input | 3 | Counter selected for reading |
| rd_data | output | 32 | Selected counter, zero-extended |
| cnt_all | output | 40 | All five counters, lane i at bits [8i+7:8i] |
| evt_pulse | output | 5 | Per-counter overflow event pulse |

## Verification
Every counter update and every event pulse is registered, so the result of the inputs held across one rising edge is visible just after that same edge. `rd_data` follows a counter combinationally, with no further delay. The bench drives inputs on the falling edge. It advances a model at the rising edge using the values then held, and compares all five counters and all five pulses at the next falling edge. This holds for the strobe sweeps, the writes and the enable rises alike.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int NUM_LANES = 5;

  typedef enum logic [2:0] {
    LANE_EXTRA = 3'd0,
    LANE_EXC   = 3'd1,
    LANE_SLEEP = 3'd2,
    LANE_LSU   = 3'd3,
    LANE_FOLD  = 3'd4
  } lane_e;
endpackage

// File: rtl/pc_inc_map.sv
module pc_inc_map #(
  parameter int FOLD_W   = 2,
  parameter int FOLD_MAX = 2,
  parameter int INC_W    = 2
) (
  input  logic                                       instr_extra_stb,
  input  logic                                       lsu_extra_stb,
  input  logic                                       fetch_stall_stb,
  input  logic                                       exc_stb,
  input  logic                                       sleep_stb,
  input  logic [FOLD_W-1:0]                          fold_n,
  output logic [pc_pkg::NUM_LANES-1:0][INC_W-1:0]    inc
);
  import pc_pkg::*;

  logic [INC_W-1:0] fold_clamped;

  always_comb begin
    if (int'(fold_n) > FOLD_MAX) fold_clamped = INC_W'(FOLD_MAX);
    else                         fold_clamped = INC_W'(fold_n);
  end

  always_comb begin
    inc             = '0;
    inc[LANE_EXTRA] = INC_W'((instr_extra_stb && !lsu_extra_stb) || fetch_stall_stb);
    inc[LANE_EXC]   = INC_W'(exc_stb);
    inc[LANE_SLEEP] = INC_W'(sleep_stb);
    inc[LANE_LSU]   = INC_W'(lsu_extra_stb);
    inc[LANE_FOLD]  = fold_clamped;
  end

  // R6: clamped fold increment never exceeds the per-cycle limit
  always_comb begin
    a_r6_fold_limit: assert (int'(inc[LANE_FOLD]) <= FOLD_MAX);
  end
endmodule

// File: rtl/pc_lane.sv
module pc_lane #(
  parameter int CNT_W = 8,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             evt
);
  logic             en_q;
  logic             en_rise;
  logic [CNT_W:0]   sum;

  assign en_rise = en && !en_q;
  assign sum     = {1'b0, cnt} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      evt  <= 1'b0;
      en_q <= 1'b0;
    end else begin
      en_q <= en;
      if (wr) begin
        cnt <= wdata;
        evt <= 1'b0;
      end else if (en_rise) begin
        cnt <= '0;
        evt <= 1'b0;
      end else begin
        cnt <= sum[CNT_W-1:0];
        evt <= en && sum[CNT_W];
      end
    end
  end

  a_r11_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt == $past(wdata)) && !evt);

  a_r10_clear_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !en_q && !wr) |=> (cnt == '0));

  a_r7_modular_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !(en && !en_q)) |=> (cnt == CNT_W'($past(cnt) + CNT_W'($past(inc)))));

  a_r9_no_event_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !evt);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/perf_event_counters.sv
module perf_event_counters #(
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 32,
  parameter int FOLD_W   = 2,
  parameter int FOLD_MAX = 2,
  parameter int SEL_W    = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 instr_extra_stb,
  input  logic                                 lsu_extra_stb,
  input  logic                                 fetch_stall_stb,
  input  logic                                 exc_stb,
  input  logic                                 sleep_stb,
  input  logic [FOLD_W-1:0]                    fold_n,
  input  logic [pc_pkg::NUM_LANES-1:0]         evt_en,
  input  logic                                 wr_en,
  input  logic [SEL_W-1:0]                     wr_sel,
  input  logic [CNT_W-1:0]                     wr_data,
  input  logic [SEL_W-1:0]                     rd_sel,
  output logic [DATA_W-1:0]                    rd_data,
  output logic [pc_pkg::NUM_LANES*CNT_W-1:0]   cnt_all,
  output logic [pc_pkg::NUM_LANES-1:0]         evt_pulse
);
  import pc_pkg::*;

  localparam int INC_W = $clog2(FOLD_MAX + 1);

  logic [NUM_LANES-1:0][INC_W-1:0] inc;
  logic [NUM_LANES-1:0][CNT_W-1:0] cnt;

  pc_inc_map #(
    .FOLD_W  (FOLD_W),
    .FOLD_MAX(FOLD_MAX),
    .INC_W   (INC_W)
  ) u_map (
    .instr_extra_stb(instr_extra_stb),
    .lsu_extra_stb  (lsu_extra_stb),
    .fetch_stall_stb(fetch_stall_stb),
    .exc_stb        (exc_stb),
    .sleep_stb      (sleep_stb),
    .fold_n         (fold_n),
    .inc            (inc)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    pc_lane #(
      .CNT_W(CNT_W),
      .INC_W(INC_W)
    ) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (evt_en[i]),
      .inc  (inc[i]),
      .wr   (wr_en && (wr_sel == SEL_W'(i))),
      .wdata(wr_data),
      .cnt  (cnt[i]),
      .evt  (evt_pulse[i])
    );
    assign cnt_all[i*CNT_W +: CNT_W] = cnt[i];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (rd_sel == SEL_W'(k)) rd_data = DATA_W'(cnt[k]);
    end
  end

  // R2: unused select codes read zero
  always_comb begin
    if (int'(rd_sel) >= NUM_LANES) a_r2_unused_sel_zero: assert (rd_data == '0);
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (evt_pulse == '0) && (cnt_all == '0));
endmodule

// File: tb/tb_perf_event_counters.sv
module tb_perf_event_counters;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_extra_stb, lsu_extra_stb, fetch_stall_stb, exc_stb, sleep_stb;
  logic [1:0]  fold_n;
  logic [4:0]  evt_en;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [2:0]  rd_sel;
  logic [31:0] rd_data;
  logic [39:0] cnt_all;
  logic [4:0]  evt_pulse;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt [5];
  bit exp_evt [5];
  bit en_prev [5];
  string lane_req [5] = '{"R3 extra", "R5 exc", "R5 sleep", "R4 lsu", "R6 fold"};

  always #2 clk = ~clk;

  perf_event_counters dut (
    .clk(clk), .rst_n(rst_n),
    .instr_extra_stb(instr_extra_stb), .lsu_extra_stb(lsu_extra_stb),
    .fetch_stall_stb(fetch_stall_stb), .exc_stb(exc_stb), .sleep_stb(sleep_stb),
    .fold_n(fold_n), .evt_en(evt_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .cnt_all(cnt_all), .evt_pulse(evt_pulse)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_strobes(int v);
    instr_extra_stb = v[0];
    lsu_extra_stb   = v[1];
    fetch_stall_stb = v[2];
    exc_stb         = v[3];
    sleep_stb       = v[4];
    fold_n          = v[6:5];
  endtask

  // one clock: model advances on the rising edge, compare at the falling edge
  task automatic step();
    int inc [5];
    @(posedge clk);
    inc[0] = ((instr_extra_stb && !lsu_extra_stb) || fetch_stall_stb) ? 1 : 0;
    inc[1] = exc_stb ? 1 : 0;
    inc[2] = sleep_stb ? 1 : 0;
    inc[3] = lsu_extra_stb ? 1 : 0;
    inc[4] = (fold_n == 2'd3) ? 2 : int'(fold_n);
    for (int i = 0; i < 5; i++) begin
      if (wr_en && int'(wr_sel) == i) begin
        exp_cnt[i] = int'(wr_data);
        exp_evt[i] = 1'b0;
      end else if (evt_en[i] && !en_prev[i]) begin
        exp_cnt[i] = 0;
        exp_evt[i] = 1'b0;
      end else begin
        exp_evt[i] = evt_en[i] && (exp_cnt[i] + inc[i] > 255);
        exp_cnt[i] = (exp_cnt[i] + inc[i]) % 256;
      end
      en_prev[i] = evt_en[i];
    end
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk({lane_req[i], " R7 count"}, int'(cnt_all[i*8 +: 8]), exp_cnt[i]);
      chk(en_prev[i] ? "R8 event" : "R9 event", int'(evt_pulse[i]), int'(exp_evt[i]));
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; set_strobes(0); evt_en = '0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    for (int i = 0; i < 5; i++) begin exp_cnt[i] = 0; exp_evt[i] = 0; en_prev[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 counters", int'(cnt_all), 0);
    chk("R1 events", int'(evt_pulse), 0);

    // sweep all strobe/fold patterns with every event enabled
    evt_en = 5'b11111;
    for (int k = 0; k < 700; k++) begin
      set_strobes(k % 128);
      step();
    end

    // same sweep with events disabled: wraps still happen, no pulses
    evt_en = 5'b00000;
    for (int k = 0; k < 700; k++) begin
      set_strobes((k * 5) % 128);
      step();
    end

    // mixed enables
    evt_en = 5'b10101;
    for (int k = 0; k < 700; k++) begin
      set_strobes((k * 3 + 1) % 128);
      step();
    end

    // R11: write beats a simultaneous increment, then the next count wraps
    evt_en = 5'b11111;
    set_strobes(0); step();
    set_strobes(7'b0000010);
    wr_en = 1'b1; wr_sel = 3'd3; wr_data = 8'd255;
    step();
    chk("R11 write over increment", int'(cnt_all[31:24]), 255);
    chk("R11 write gives no event", int'(evt_pulse[3]), 0);
    wr_en = 1'b0;
    step();
    chk("R7 wrap to zero", int'(cnt_all[31:24]), 0);
    chk("R8 wrap event", int'(evt_pulse[3]), 1);
    step();
    chk("R8 pulse lasts one cycle", int'(evt_pulse[3]), 0);

    // R9: disabled lane wraps silently
    evt_en = 5'b11101; set_strobes(0);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'd254; step();
    wr_en = 1'b0; set_strobes(7'b0001000); step(); step();
    chk("R9 wrapped value", int'(cnt_all[15:8]), 0);
    chk("R9 no event", int'(evt_pulse[1]), 0);

    // R6: fold of 3 counts as 2, from 254 wraps
    set_strobes(0);
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'd254; step();
    wr_en = 1'b0; fold_n = 2'd3; step();
    chk("R6 fold clamp wrap", int'(cnt_all[39:32]), 0);
    chk("R8 fold wrap event", int'(evt_pulse[4]), 1);

    // R10: enable rise clears despite increment strobe
    set_strobes(0); evt_en = 5'b11110;
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'd77; step();
    wr_en = 1'b0; instr_extra_stb = 1'b1; step();
    evt_en = 5'b11111; step();
    chk("R10 clear on enable", int'(cnt_all[7:0]), 0);
    step();
    chk("R10 counting resumes", int'(cnt_all[7:0]), 1);

    // R11: write beats enable-rise clear
    evt_en = 5'b11011; set_strobes(0); step();
    evt_en = 5'b11111; wr_en = 1'b1; wr_sel = 3'd2; wr_data = 8'd42; step();
    wr_en = 1'b0;
    chk("R11 write over clear", int'(cnt_all[23:16]), 42);

    // R2: read port over every select code
    set_strobes(0);
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #1;
      chk("R2 read port", int'(rd_data), (s < 5) ? exp_cnt[s] : 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule